// File: doc/BRIEF.md
# Multi-Output PWM Edge Generator

This block drives seven gate signals from one shared period counter: four main switch drives (indices 0 to 3), one auxiliary drive (index 4) and two synchronous rectifier drives (indices 5 and 6). Each output has its own programmed turn-on and turn-off time inside the period. A modulation value from the control loop can shift any individual edge. Each edge selects whether an increase in modulation makes it later or earlier.

All timing words are double-buffered. An update strobe copies the input words into shadow storage. The shadow set becomes active only when the next period begins, so an output never sees half of an old timing and half of a new one. The loop modulation is sampled once per period in the same way. When pulse skipping is armed and the sampled modulation is below a floor, every pulse of that period is suppressed. The floor is a percentage of the period. A disable mask can hold any single output low at any time.

Top module: `pwm_multi_edge`

## Requirements
- R1: The period counter starts at 0 and counts up by one per clock. After reaching active period minus one it returns to 0, so one period lasts `period` clocks. A period of 0 or 1 makes the counter stay at 0.
- R2: Output i is high exactly in the cycles where the counter value c satisfies rise_i <= c < fall_i. Here rise_i and fall_i are that output's effective edge times. If rise_i > fall_i, the output stays low for the whole period.
- R3: An output whose effective rise time equals its effective fall time stays low for the whole period.
- R4: Each edge has a 2-bit setting word. If bit 0 (modulate enable) is 0, the edge sits at its programmed time whatever the modulation value is.
- R5: If bit 0 is 1, bit 1 (direction) selects the shift. With bit 1 = 0 the edge time is programmed time + modulation. With bit 1 = 1 it is programmed time - modulation.
- R6: An effective edge time that would fall below 0 becomes 0. One that would exceed the active period becomes the active period.
- R7: Let F = floor(period * floor_pct / 100). If skip enable is set and the sampled modulation is below F, all seven outputs stay low for that period. If skip enable is clear, the floor has no effect.
- R8: Setting bit i of the disable mask forces output i low in the same cycle. The other outputs are not affected.
- R9: A strobe on latch_i captures the period, edge times, setting words, floor and skip enable into shadow storage. The shadow values take effect at the first period start after that strobe. Input changes without a strobe never change the outputs.
- R10: While reset is held and directly after it, all outputs are low, the counter is 0, the active period is 0 and all active edge times are 0.
- R11: The modulation input is sampled at each period start and held for the whole period. Changes within a period do not affect that period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| period_i | input | CNT_W | Period length in clocks (shadowed) |
| rise_time_i | input | NUM_OUT*CNT_W | Programmed rise time per output, output i in slice i |
| fall_time_i | input | NUM_OUT*CNT_W | Programmed fall time per output |
| rise_cfg_i | input | NUM_OUT*2 | Rise-edge setting words: bit 0 enable, bit 1 direction |
| fall_cfg_i | input | NUM_OUT*2 | Fall-edge setting words, same encoding |
| mod_i | input | MOD_W | Loop modulation in clock counts |
| mod_floor_pct_i | input | 7 | Pulse-skip floor as percent of the period |
| skip_en_i | input | 1 | Arms pulse skipping |
| out_disable_i | input | NUM_OUT | Per-output force-low mask |
| latch_i | input | 1 | Update strobe for the shadow set |
| gate_o | output | NUM_OUT | Gate drive outputs |

## Verification
The bench builds the block with CNT_W = 5 and MOD_W = 4, with all seven outputs kept. With these widths a full sweep of every modulation value takes little time, and edge times pushed past the period, or below zero, come up in every sweep. The bench also tries all 128 disable masks. It uses periods of 12 and 20 clocks, so the skip floor cuts through the middle of the modulation range. It changes the inputs and pulses the strobe in the middle of a period, so the hand-over at the period boundary can be seen.

// File: rtl/pwm_edge_pkg.sv
// Shared constants and types for the multi-output PWM edge generator.
// Assumes every edge setting word is 2 bits: bit 0 enable, bit 1 direction.
package pwm_edge_pkg;
    localparam int CFG_W = 2;   // width of one edge setting word
    localparam int PCT_W = 7;   // width of the skip floor percentage

    // Edge setting word; packed so that bit 1 is direction, bit 0 enable
    typedef struct packed {
        logic sign;    // 0: modulation delays edge, 1: advances it
        logic mod_en;  // 1: edge follows the modulation
    } edge_cfg_t;
endpackage

// File: rtl/pwm_timebase.sv
// Period counter with shadowed period, skip floor and skip enable.
// It samples the loop modulation at each period start and raises the
// pulse-skip decision for the current period.
// Assumes latch_i is a single-cycle strobe; a period of 0 behaves as 1.
module pwm_timebase
    import pwm_edge_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int MOD_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] period_i,
    input  logic [PCT_W-1:0] floor_pct_i,
    input  logic             skip_en_i,
    input  logic [MOD_W-1:0] mod_i,
    input  logic             latch_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] per_o,
    output logic [MOD_W-1:0] mod_o,
    output logic             swap_o,
    output logic             skip_o
);
    localparam int PW = CNT_W + PCT_W;
    localparam int CW = (PW > MOD_W) ? PW : MOD_W;

    logic [CNT_W-1:0] cnt_q, per_sh, per_act, lim;
    logic [PCT_W-1:0] pct_sh, pct_act;
    logic             skp_sh, skp_act, pend_q, wrap;
    logic [MOD_W-1:0] mod_act;
    logic [PW-1:0]    prod;
    logic [CW-1:0]    floor_cnt;

    // Last count of the period; zero period treated as one clock
    always_comb begin
        lim  = (per_act == '0) ? '0 : per_act - 1'b1;
        wrap = (cnt_q >= lim);
    end

    // Counter, pending flag, shadow capture and active hand-over
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            per_sh  <= '0;
            per_act <= '0;
            pct_sh  <= '0;
            pct_act <= '0;
            skp_sh  <= 1'b0;
            skp_act <= 1'b0;
            pend_q  <= 1'b0;
            mod_act <= '0;
        end else begin
            pend_q <= latch_i | (pend_q & ~wrap);
            if (latch_i) begin
                per_sh <= period_i;
                pct_sh <= floor_pct_i;
                skp_sh <= skip_en_i;
            end
            if (wrap) begin
                cnt_q   <= '0;
                mod_act <= mod_i;
                if (pend_q) begin
                    per_act <= per_sh;
                    pct_act <= pct_sh;
                    skp_act <= skp_sh;
                end
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // Skip floor in counts: period * percent / 100, rounded down
    always_comb begin
        prod      = PW'(per_act) * PW'(pct_act);
        floor_cnt = CW'(prod / PW'(100));
        skip_o    = skp_act & (CW'(mod_act) < floor_cnt);
    end

    assign cnt_o  = cnt_q;
    assign per_o  = per_act;
    assign mod_o  = mod_act;
    assign swap_o = wrap & pend_q;

    p_wrap_restart_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q >= lim) |=> (cnt_q == '0));
    p_count_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q < lim) |=> (cnt_q == $past(cnt_q) + 1'b1));
    p_period_swap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(per_act) |-> (cnt_q == '0));
    p_mod_held_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != '0) |-> $stable(mod_act));
endmodule

// File: rtl/pwm_out_unit.sv
// One gate output. It holds shadow and active copies of its two edge times
// and setting words, places both edges using the period's modulation, and
// compares them against the shared counter.
// Assumes swap_i only pulses on the cycle the counter wraps.
module pwm_out_unit
    import pwm_edge_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int MOD_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             latch_i,
    input  logic             swap_i,
    input  logic [CNT_W-1:0] rise_i,
    input  logic [CNT_W-1:0] fall_i,
    input  edge_cfg_t        rise_cfg_i,
    input  edge_cfg_t        fall_cfg_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [CNT_W-1:0] per_i,
    input  logic [MOD_W-1:0] mod_i,
    output logic             gate_o
);
    localparam int SW = ((CNT_W > MOD_W) ? CNT_W : MOD_W) + 2;

    logic [CNT_W-1:0] rise_sh, fall_sh, rise_act, fall_act, rise_eff, fall_eff;
    edge_cfg_t        rcfg_sh, fcfg_sh, rcfg_act, fcfg_act;

    // Place one edge: optional shift, then limit to [0, period]
    function automatic logic [CNT_W-1:0] place_edge(
        input logic [CNT_W-1:0] base,
        input edge_cfg_t        cfg,
        input logic [MOD_W-1:0] m,
        input logic [CNT_W-1:0] per
    );
        logic [SW-1:0] b, mm, t;
        b  = SW'(base);
        mm = SW'(m);
        if (!cfg.mod_en)    t = b;
        else if (!cfg.sign) t = b + mm;
        else if (mm > b)    t = '0;
        else                t = b - mm;
        if (t > SW'(per))   t = SW'(per);
        return t[CNT_W-1:0];
    endfunction

    // Shadow capture on strobe, active copy at the period start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rise_sh  <= '0;
            fall_sh  <= '0;
            rise_act <= '0;
            fall_act <= '0;
            rcfg_sh  <= '0;
            fcfg_sh  <= '0;
            rcfg_act <= '0;
            fcfg_act <= '0;
        end else begin
            if (latch_i) begin
                rise_sh <= rise_i;
                fall_sh <= fall_i;
                rcfg_sh <= rise_cfg_i;
                fcfg_sh <= fall_cfg_i;
            end
            if (swap_i) begin
                rise_act <= rise_sh;
                fall_act <= fall_sh;
                rcfg_act <= rcfg_sh;
                fcfg_act <= fcfg_sh;
            end
        end
    end

    // Effective edges and the on-window compare
    always_comb begin
        rise_eff = place_edge(rise_act, rcfg_act, mod_i, per_i);
        fall_eff = place_edge(fall_act, fcfg_act, mod_i, per_i);
        gate_o   = (cnt_i >= rise_eff) && (cnt_i < fall_eff);
    end

    p_edge_in_period_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_eff <= per_i) && (fall_eff <= per_i));
    p_equal_edges_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_eff == fall_eff) |-> !gate_o);
    p_active_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_i != '0) |-> ($stable(rise_act) && $stable(fall_act)));
endmodule

// File: rtl/pwm_multi_edge.sv
// Top of the multi-output PWM edge generator. One shared timebase, one
// output unit per gate, then the period-wide skip and the per-output
// disable mask. Output order: 0..3 main, 4 auxiliary, 5..6 rectifiers.
// Assumes all inputs are synchronous to clk.
module pwm_multi_edge
    import pwm_edge_pkg::*;
#(
    parameter int NUM_OUT = 7,
    parameter int CNT_W   = 8,
    parameter int MOD_W   = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [CNT_W-1:0]         period_i,
    input  logic [NUM_OUT*CNT_W-1:0] rise_time_i,
    input  logic [NUM_OUT*CNT_W-1:0] fall_time_i,
    input  logic [NUM_OUT*CFG_W-1:0] rise_cfg_i,
    input  logic [NUM_OUT*CFG_W-1:0] fall_cfg_i,
    input  logic [MOD_W-1:0]         mod_i,
    input  logic [PCT_W-1:0]         mod_floor_pct_i,
    input  logic                     skip_en_i,
    input  logic [NUM_OUT-1:0]       out_disable_i,
    input  logic                     latch_i,
    output logic [NUM_OUT-1:0]       gate_o
);
    logic [CNT_W-1:0]   cnt, per;
    logic [MOD_W-1:0]   mod_act;
    logic               swap, skip;
    logic [NUM_OUT-1:0] raw;

    pwm_timebase #(.CNT_W(CNT_W), .MOD_W(MOD_W)) u_tb (
        .clk        (clk),
        .rst_n      (rst_n),
        .period_i   (period_i),
        .floor_pct_i(mod_floor_pct_i),
        .skip_en_i  (skip_en_i),
        .mod_i      (mod_i),
        .latch_i    (latch_i),
        .cnt_o      (cnt),
        .per_o      (per),
        .mod_o      (mod_act),
        .swap_o     (swap),
        .skip_o     (skip)
    );

    // One edge unit per gate output
    for (genvar g = 0; g < NUM_OUT; g++) begin : g_out
        pwm_out_unit #(.CNT_W(CNT_W), .MOD_W(MOD_W)) u_unit (
            .clk       (clk),
            .rst_n     (rst_n),
            .latch_i   (latch_i),
            .swap_i    (swap),
            .rise_i    (rise_time_i[g*CNT_W +: CNT_W]),
            .fall_i    (fall_time_i[g*CNT_W +: CNT_W]),
            .rise_cfg_i(edge_cfg_t'(rise_cfg_i[g*CFG_W +: CFG_W])),
            .fall_cfg_i(edge_cfg_t'(fall_cfg_i[g*CFG_W +: CFG_W])),
            .cnt_i     (cnt),
            .per_i     (per),
            .mod_i     (mod_act),
            .gate_o    (raw[g])
        );
    end

    // Period-wide skip and per-output force-low
    assign gate_o = skip ? '0 : (raw & ~out_disable_i);
endmodule

// File: tb/sim_pwm_multi_edge.sv
module sim_pwm_multi_edge;
    localparam int CLK_PERIOD = 10;
    localparam int N  = 7;
    localparam int CW = 5;
    localparam int MW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [CW-1:0]   period_i = '0;
    logic [CW-1:0]   in_rise [N];
    logic [CW-1:0]   in_fall [N];
    logic [1:0]      in_rcfg [N];
    logic [1:0]      in_fcfg [N];
    logic [N*CW-1:0] rise_bus, fall_bus;
    logic [N*2-1:0]  rcfg_bus, fcfg_bus;
    logic [MW-1:0]   mod_i = '0;
    logic [6:0]      pct_i = '0;
    logic            skip_en_i = 1'b0;
    logic [N-1:0]    dis_i = '0;
    logic            latch_i = 1'b0;
    logic [N-1:0]    gate_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    always_comb begin
        for (int i = 0; i < N; i++) begin
            rise_bus[i*CW +: CW] = in_rise[i];
            fall_bus[i*CW +: CW] = in_fall[i];
            rcfg_bus[i*2 +: 2]   = in_rcfg[i];
            fcfg_bus[i*2 +: 2]   = in_fcfg[i];
        end
    end

    pwm_multi_edge #(.NUM_OUT(N), .CNT_W(CW), .MOD_W(MW)) u0 (
        .clk            (clk),
        .rst_n          (rst_n),
        .period_i       (period_i),
        .rise_time_i    (rise_bus),
        .fall_time_i    (fall_bus),
        .rise_cfg_i     (rcfg_bus),
        .fall_cfg_i     (fcfg_bus),
        .mod_i          (mod_i),
        .mod_floor_pct_i(pct_i),
        .skip_en_i      (skip_en_i),
        .out_disable_i  (dis_i),
        .latch_i        (latch_i),
        .gate_o         (gate_o)
    );

    // Reference state, written from the requirement text
    int m_cnt, m_pact, m_psh, m_pct_sh, m_pct_act, m_mod;
    bit m_sk_sh, m_sk_act, m_pend;
    int s_rise [N], s_fall [N], s_rcfg [N], s_fcfg [N];
    int a_rise [N], a_fall [N], a_rcfg [N], a_fcfg [N];

    function automatic int last_count(input int p);
        return (p <= 1) ? 0 : p - 1;   // R1
    endfunction

    function automatic int edge_at(input int base, input int cfg, input int m, input int p);
        int t;
        t = base;
        if (cfg % 2 == 1) t = (cfg / 2 == 0) ? base + m : base - m;   // R4 R5
        if (t < 0) t = 0;                                              // R6
        if (t > p) t = p;
        return t;
    endfunction

    function automatic logic [N-1:0] expect_gates();
        logic [N-1:0] e;
        bit skip;
        skip = m_sk_act && ((m_mod + 1) * 100 <= m_pact * m_pct_act);  // R7
        for (int i = 0; i < N; i++) begin
            int r, f;
            r = edge_at(a_rise[i], a_rcfg[i], m_mod, m_pact);
            f = edge_at(a_fall[i], a_fcfg[i], m_mod, m_pact);
            e[i] = (m_cnt >= r) && (m_cnt < f) && !skip && !dis_i[i];  // R2 R3 R8
        end
        return e;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt <= 0; m_pact <= 0; m_psh <= 0; m_pend <= 0;
            m_pct_sh <= 0; m_pct_act <= 0; m_sk_sh <= 0; m_sk_act <= 0; m_mod <= 0;
            for (int i = 0; i < N; i++) begin
                s_rise[i] <= 0; s_fall[i] <= 0; s_rcfg[i] <= 0; s_fcfg[i] <= 0;
                a_rise[i] <= 0; a_fall[i] <= 0; a_rcfg[i] <= 0; a_fcfg[i] <= 0;
            end
        end else begin
            bit w;
            w = (m_cnt >= last_count(m_pact));
            m_pend <= latch_i || (m_pend && !w);            // R9
            if (latch_i) begin
                m_psh <= period_i; m_pct_sh <= pct_i; m_sk_sh <= skip_en_i;
                for (int i = 0; i < N; i++) begin
                    s_rise[i] <= in_rise[i]; s_fall[i] <= in_fall[i];
                    s_rcfg[i] <= in_rcfg[i]; s_fcfg[i] <= in_fcfg[i];
                end
            end
            if (w) begin
                m_cnt <= 0;
                m_mod <= mod_i;                              // R11
                if (m_pend) begin
                    m_pact <= m_psh; m_pct_act <= m_pct_sh; m_sk_act <= m_sk_sh;
                    for (int i = 0; i < N; i++) begin
                        a_rise[i] <= s_rise[i]; a_fall[i] <= s_fall[i];
                        a_rcfg[i] <= s_rcfg[i]; a_fcfg[i] <= s_fcfg[i];
                    end
                end
            end else begin
                m_cnt <= m_cnt + 1;
            end
        end
    end

    task automatic check_val(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: gate_o=%b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    // One cycle: settle past the falling edge, then compare
    task automatic cyc(input string tag);
        @(negedge clk);
        #1;
        check_val(tag, gate_o, expect_gates());
    endtask

    task automatic run(input string tag, input int n);
        for (int k = 0; k < n; k++) cyc(tag);
    endtask

    task automatic strobe(input string tag);
        latch_i = 1'b1;
        cyc(tag);
        latch_i = 1'b0;
    endtask

    task automatic set_out(input int i, input int r, input int f, input int rc, input int fc);
        in_rise[i] = CW'(r); in_fall[i] = CW'(f);
        in_rcfg[i] = 2'(rc); in_fcfg[i] = 2'(fc);
    endtask

    initial begin
        for (int i = 0; i < N; i++) set_out(i, 0, 0, 0, 0);
        repeat (3) @(negedge clk);
        #1;
        check_val("R10 reset", gate_o, '0);
        rst_n = 1'b1;
        cyc("R10 after reset");

        // Fixed windows over a 12-clock period
        period_i = 5'd12;
        set_out(0, 0, 6, 0, 0);
        set_out(1, 6, 12, 0, 0);
        set_out(2, 3, 9, 0, 0);
        set_out(3, 9, 3, 0, 0);
        set_out(4, 2, 11, 0, 0);
        set_out(5, 5, 5, 0, 0);     // R3 equal edges
        set_out(6, 0, 12, 0, 0);
        strobe("R9 first load");
        run("R1 R2 fixed windows", 40);
        run("R3 equal edges", 12);

        // Modulated edges in both directions, plus a fixed one
        set_out(0, 2, 6, 1, 0);     // rise later
        set_out(1, 1, 11, 0, 3);    // fall earlier
        set_out(2, 3, 5, 1, 1);     // both later
        set_out(3, 4, 8, 2, 2);     // direction set, enable clear: R4
        set_out(4, 8, 10, 3, 1);    // rise earlier, fall later
        strobe("R9 load mod");
        for (int m = 0; m < 16; m++) begin
            mod_i = MW'(m);
            run("R4 R5 modulation sweep", 13);
        end
        for (int k = 0; k < 40; k++) begin
            mod_i = MW'(k * 7);
            cyc("R11 mid-period modulation");
        end

        // Clamp at both ends of the period
        set_out(0, 10, 11, 0, 1);   // fall pushed past 12
        set_out(1, 2, 7, 3, 0);     // rise pushed below 0
        set_out(2, 11, 12, 1, 1);
        strobe("R9 load clamp");
        for (int m = 0; m < 16; m++) begin
            mod_i = MW'(m);
            run("R6 clamp sweep", 13);
        end

        // Pulse skipping: floor of 50% of 20 clocks is 10
        period_i = 5'd20;
        pct_i = 7'd50;
        skip_en_i = 1'b1;
        strobe("R9 load skip");
        for (int m = 0; m < 16; m++) begin
            mod_i = MW'(m);
            run("R7 skip sweep", 21);
        end
        skip_en_i = 1'b0;
        strobe("R9 skip off");
        for (int m = 0; m < 8; m++) begin
            mod_i = MW'(m);
            run("R7 skip disabled", 21);
        end

        // Every disable mask
        for (int d = 0; d < 128; d++) begin
            dis_i = N'(d);
            run("R8 disable mask", 3);
        end
        dis_i = '0;

        // Inputs change without a strobe, then a strobe mid-period
        period_i = 5'd9;
        for (int i = 0; i < N; i++) set_out(i, 1, 4, 0, 0);
        run("R9 no strobe", 45);
        run("R9 pre strobe", 7);
        strobe("R9 mid-period strobe");
        run("R9 after strobe", 30);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule